// File: doc/BRIEF.md
# Shared-Logic Frequency Ratio Governor

This block picks the clock ratio requested for the logic that all cores share, such as the last-level cache and the on-die fabric. An autonomous control loop counts shared-cache accesses over a long evaluation window. At the end of each window it moves its own ratio one step up, one step down, or leaves it alone. That ratio is then clamped to a floor and ceiling that software programs through a write port. Writing the same value to floor and ceiling pins the ratio. A power-limit flag overrides the clamp and forces the request down to a throttle ratio, even below a pinned floor, so a software setting is only a recommendation while the limit is exceeded.

A change of the requested ratio is applied only on the tick of a periodic update interval. The delay from a new target to the change therefore lies anywhere between zero and one full interval. Each applied change opens a fixed stall period, shown on the busy output, while the new clock settles. No further change is applied until that period has ended.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready pair and no back-pressure. A limit write is a single-cycle strobe that is always taken in the cycle it is presented, and it either updates both fields or neither.

Top module: `uncore_ratio_gov`

## Requirements
- R1: After reset the requested ratio equals HW_MAX (24 by default), busy is low, and the floor and ceiling hold HW_MIN (12) and HW_MAX (24).
- R2: The loop counts the cycles with cache_act high over each evaluation window of EVAL_TICKS update ticks (64 cycles by default). At the window's end, a count above HI_THRESH (48) raises the loop ratio by one, a count below LO_THRESH (16) lowers it by one, and any other count holds it. The loop ratio saturates at HW_MIN and HW_MAX.
- R3: The requested ratio changes only on an update tick, which occurs every TICK_PERIOD (16) cycles. The first tick is 16 cycles after reset is released. A loop decision taken at a window's end becomes visible on ratio_req after the next tick.
- R4: ratio_busy rises with every change of ratio_req and stays high for exactly STALL_CYCLES (20) cycles. No change is applied while it is high, so a tick that falls inside the stall is skipped.
- R5: A write with cfg_we high is accepted only when cfg_min <= cfg_max and both lie inside [HW_MIN, HW_MAX]. Any other write is ignored and the previous floor and ceiling are kept.
- R6: Without the power override, the target is the loop ratio clamped to [floor, ceiling]. A floor equal to the ceiling pins the ratio to that value whatever the activity.
- R7: While pwr_limit_hit is high, the target is the lower of the clamped ratio and PWR_RATIO (14), even when that is below the software floor. When the flag drops, the clamped ratio returns at a later tick.
- R8: ratio_req always lies within [HW_MIN, HW_MAX].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Single-cycle write strobe for the floor and ceiling fields |
| cfg_min | input | 7 | New ratio floor |
| cfg_max | input | 7 | New ratio ceiling |
| cache_act | input | 1 | High in each cycle with a shared-cache access |
| pwr_limit_hit | input | 1 | Power limit currently exceeded |
| ratio_req | output | 7 | Requested ratio for the shared logic |
| ratio_busy | output | 1 | High during the stall that follows each ratio change |

## Verification
The loop is driven with whole windows of three activity shapes: no accesses, an access in every cycle, and accesses in alternate cycles. These separate the step-down, step-up and hold decisions, and repeated full-activity windows show saturation at the ceiling. A power-limited window with neutral activity checks that the throttle overrides the loop and that the loop ratio comes back once the flag drops. Directed sequences time the gap between a window decision and its tick and measure the stall length. They show that a tick inside the stall is skipped, and that a pinned window holds against full activity yet gives way to the power flag. They also check that inverted or out-of-range writes leave the clamp unchanged, and that the clamp floor stops the loop until the window is widened.

// File: rtl/ugov_pkg.sv
package ugov_pkg;
  localparam int RATIO_W = 7;
  typedef logic [RATIO_W-1:0] ratio_t;

  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_UP   = 2'd1,
    DEC_DOWN = 2'd2
  } step_dec_e;

  function automatic ratio_t clamp_ratio(input ratio_t val, input ratio_t lo, input ratio_t hi);
    if (val < lo)      return lo;
    else if (val > hi) return hi;
    else               return val;
  endfunction
endpackage

// File: rtl/ugov_tick_gen.sv
module ugov_tick_gen #(
  parameter int TICK_PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int TW = (TICK_PERIOD > 2) ? $clog2(TICK_PERIOD) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TICK_PERIOD - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == TLAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ugov_limit_reg.sv
module ugov_limit_reg
  import ugov_pkg::*;
#(
  parameter int HW_MIN = 12,
  parameter int HW_MAX = 24
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cfg_we_i,
  input  ratio_t cfg_min_i,
  input  ratio_t cfg_max_i,
  output ratio_t lim_min_o,
  output ratio_t lim_max_o
);
  localparam ratio_t HW_MIN_C = RATIO_W'(HW_MIN);
  localparam ratio_t HW_MAX_C = RATIO_W'(HW_MAX);

  ratio_t lim_min_q, lim_max_q;
  logic   wr_ok;

  assign wr_ok = cfg_we_i && (cfg_min_i <= cfg_max_i)
              && (cfg_min_i >= HW_MIN_C) && (cfg_max_i <= HW_MAX_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_min_q <= HW_MIN_C;
      lim_max_q <= HW_MAX_C;
    end else if (wr_ok) begin
      lim_min_q <= cfg_min_i;
      lim_max_q <= cfg_max_i;
    end
  end

  assign lim_min_o = lim_min_q;
  assign lim_max_o = lim_max_q;

  // R5
  bad_write_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we_i && (cfg_min_i > cfg_max_i)) |-> ($stable(lim_min_q) && $stable(lim_max_q)));

  // R5
  lim_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lim_min_q <= lim_max_q);
endmodule

// File: rtl/ugov_activity_eval.sv
module ugov_activity_eval
  import ugov_pkg::*;
#(
  parameter int HW_MIN      = 12,
  parameter int HW_MAX      = 24,
  parameter int TICK_PERIOD = 16,
  parameter int EVAL_TICKS  = 4,
  parameter int HI_THRESH   = 48,
  parameter int LO_THRESH   = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_i,
  input  logic   act_i,
  output ratio_t auto_o
);
  localparam int WIN_CYCLES = EVAL_TICKS * TICK_PERIOD;
  localparam int CNT_W      = $clog2(WIN_CYCLES + 1);
  localparam int WT_W       = (EVAL_TICKS > 2) ? $clog2(EVAL_TICKS) : 1;
  localparam logic [WT_W-1:0]  WLAST = WT_W'(EVAL_TICKS - 1);
  localparam logic [CNT_W-1:0] HI_C  = CNT_W'(HI_THRESH);
  localparam logic [CNT_W-1:0] LO_C  = CNT_W'(LO_THRESH);
  localparam ratio_t HW_MIN_C = RATIO_W'(HW_MIN);
  localparam ratio_t HW_MAX_C = RATIO_W'(HW_MAX);

  logic [CNT_W-1:0] cnt_q, total;
  logic [WT_W-1:0]  wcnt_q;
  logic             win_end;
  step_dec_e        dec;
  ratio_t           auto_q;

  assign win_end = tick_i && (wcnt_q == WLAST);
  assign total   = cnt_q + CNT_W'(act_i);

  always_comb begin
    if (total > HI_C)      dec = DEC_UP;
    else if (total < LO_C) dec = DEC_DOWN;
    else                   dec = DEC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wcnt_q <= '0;
      auto_q <= HW_MAX_C;
    end else if (win_end) begin
      cnt_q  <= '0;
      wcnt_q <= '0;
      unique case (dec)
        DEC_UP:   if (auto_q < HW_MAX_C) auto_q <= auto_q + 1'b1;
        DEC_DOWN: if (auto_q > HW_MIN_C) auto_q <= auto_q - 1'b1;
        default:  auto_q <= auto_q;
      endcase
    end else begin
      cnt_q <= total;
      if (tick_i) wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign auto_o = auto_q;

  // R2
  loop_at_window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(auto_q) |-> $past(win_end));

  // R2
  loop_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(auto_q) |-> ((auto_q == $past(auto_q) + RATIO_W'(1)) ||
                          (auto_q == $past(auto_q) - RATIO_W'(1))));
endmodule

// File: rtl/ugov_transition.sv
module ugov_transition
  import ugov_pkg::*;
#(
  parameter int HW_MAX       = 24,
  parameter int STALL_CYCLES = 20
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick_i,
  input  ratio_t target_i,
  output ratio_t ratio_o,
  output logic   busy_o
);
  localparam int STW = (STALL_CYCLES > 2) ? $clog2(STALL_CYCLES) : 1;
  localparam logic [STW-1:0] SLAST = STW'(STALL_CYCLES - 1);
  localparam ratio_t HW_MAX_C = RATIO_W'(HW_MAX);

  ratio_t         ratio_q;
  logic           busy_q;
  logic [STW-1:0] scnt_q;
  logic           apply;

  assign apply = tick_i && !busy_q && (target_i != ratio_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q <= HW_MAX_C;
      busy_q  <= 1'b0;
      scnt_q  <= '0;
    end else if (apply) begin
      ratio_q <= target_i;
      busy_q  <= 1'b1;
      scnt_q  <= SLAST;
    end else if (busy_q) begin
      if (scnt_q == '0) busy_q <= 1'b0;
      else              scnt_q <= scnt_q - 1'b1;
    end
  end

  assign ratio_o = ratio_q;
  assign busy_o  = busy_q;

  // R3
  change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> $past(tick_i));

  // R4
  change_starts_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> $rose(busy_q));

  // R4
  no_change_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_q) |-> $stable(ratio_q));
endmodule

// File: rtl/uncore_ratio_gov.sv
module uncore_ratio_gov
  import ugov_pkg::*;
#(
  parameter int HW_MIN       = 12,
  parameter int HW_MAX       = 24,
  parameter int PWR_RATIO    = 14,
  parameter int TICK_PERIOD  = 16,
  parameter int EVAL_TICKS   = 4,
  parameter int STALL_CYCLES = 20,
  parameter int HI_THRESH    = 48,
  parameter int LO_THRESH    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [6:0] cfg_min,
  input  logic [6:0] cfg_max,
  input  logic       cache_act,
  input  logic       pwr_limit_hit,
  output logic [6:0] ratio_req,
  output logic       ratio_busy
);
  localparam ratio_t PWR_C    = RATIO_W'(PWR_RATIO);
  localparam ratio_t HW_MIN_C = RATIO_W'(HW_MIN);
  localparam ratio_t HW_MAX_C = RATIO_W'(HW_MAX);

  logic   tick;
  ratio_t lim_min, lim_max, auto_r, clamped, target;

  ugov_tick_gen #(.TICK_PERIOD(TICK_PERIOD)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  ugov_limit_reg #(.HW_MIN(HW_MIN), .HW_MAX(HW_MAX)) u_limits (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we),
    .cfg_min_i(cfg_min), .cfg_max_i(cfg_max),
    .lim_min_o(lim_min), .lim_max_o(lim_max)
  );

  ugov_activity_eval #(
    .HW_MIN(HW_MIN), .HW_MAX(HW_MAX), .TICK_PERIOD(TICK_PERIOD),
    .EVAL_TICKS(EVAL_TICKS), .HI_THRESH(HI_THRESH), .LO_THRESH(LO_THRESH)
  ) u_eval (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .act_i(cache_act), .auto_o(auto_r)
  );

  always_comb begin
    clamped = clamp_ratio(auto_r, lim_min, lim_max);
    target  = (pwr_limit_hit && (clamped > PWR_C)) ? PWR_C : clamped;
  end

  ugov_transition #(.HW_MAX(HW_MAX), .STALL_CYCLES(STALL_CYCLES)) u_trans (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .target_i(target),
    .ratio_o(ratio_req), .busy_o(ratio_busy)
  );

  // R8
  ratio_in_hw_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_req >= HW_MIN_C) && (ratio_req <= HW_MAX_C));

  // R7
  pwr_cap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_limit_hit |-> (target <= PWR_C || target <= lim_min));
endmodule

// File: tb/uncore_ratio_gov_tb.sv
module uncore_ratio_gov_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_min = '0;
  logic [6:0] cfg_max = '0;
  logic       cache_act = 1'b0;
  logic       pwr_limit_hit = 1'b0;
  logic [6:0] ratio_req;
  logic       ratio_busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uncore_ratio_gov u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_min(cfg_min), .cfg_max(cfg_max),
    .cache_act(cache_act), .pwr_limit_hit(pwr_limit_hit),
    .ratio_req(ratio_req), .ratio_busy(ratio_busy)
  );

  // {pattern[9:8] (0 none, 1 every cycle, 2 alternate), pwr[7], expected ratio[6:0]}
  localparam logic [9:0] VEC [10] = '{
    {2'd2, 1'b0, 7'd24}, {2'd0, 1'b0, 7'd23}, {2'd0, 1'b0, 7'd22},
    {2'd1, 1'b0, 7'd23}, {2'd0, 1'b0, 7'd22}, {2'd2, 1'b1, 7'd14},
    {2'd2, 1'b0, 7'd22}, {2'd1, 1'b0, 7'd23}, {2'd1, 1'b0, 7'd24},
    {2'd1, 1'b0, 7'd24}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cache_act = 1'b0; pwr_limit_hit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_window(input logic [1:0] pat);
    for (int i = 0; i < 64; i++) begin
      case (pat)
        2'd0:    cache_act = 1'b0;
        2'd1:    cache_act = 1'b1;
        default: cache_act = i[0];
      endcase
      @(negedge clk);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_lim(input int mn, input int mx);
    cfg_min = 7'(mn); cfg_max = 7'(mx); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    int busy_cnt;
    apply_reset();
    check(ratio_req == 7'd24, "R1 reset ratio", ratio_req, 24);
    check(ratio_busy == 1'b0, "R1 reset busy", ratio_busy, 0);

    for (int v = 0; v < 10; v++) begin
      pwr_limit_hit = VEC[v][7];
      run_window(VEC[v][9:8]);
      run_window(2'd2);
      check(ratio_req == VEC[v][6:0],
            $sformatf("R2/R7 vector %0d", v), ratio_req, VEC[v][6:0]);
    end
    pwr_limit_hit = 1'b0;

    // Tick timing and stall length after a fresh reset
    apply_reset();
    run_window(2'd0);
    idle_cycles(6);
    check(ratio_req == 7'd24, "R3 no change before tick", ratio_req, 24);
    idle_cycles(9);
    check(ratio_req == 7'd24 && !ratio_busy, "R3 still old at cycle 79", ratio_req, 24);
    idle_cycles(1);
    check(ratio_req == 7'd23 && ratio_busy, "R3 change at tick 80", ratio_req, 23);
    pwr_limit_hit = 1'b1;
    busy_cnt = 1;
    for (int c = 81; c < 112; c++) begin
      @(negedge clk);
      if (ratio_busy) busy_cnt++;
    end
    check(ratio_req == 7'd23, "R4 tick inside stall skipped", ratio_req, 23);
    check(busy_cnt == 20, "R4 stall length", busy_cnt, 20);
    idle_cycles(1);
    check(ratio_req == 7'd14, "R7 throttle at next tick", ratio_req, 14);
    pwr_limit_hit = 1'b0;

    // Pinning
    write_lim(18, 18);
    cache_act = 1'b1;
    idle_cycles(200);
    check(ratio_req == 7'd18, "R6 pinned under full activity", ratio_req, 18);
    pwr_limit_hit = 1'b1;
    idle_cycles(64);
    check(ratio_req == 7'd14, "R7 power below pinned floor", ratio_req, 14);
    pwr_limit_hit = 1'b0;
    idle_cycles(64);
    check(ratio_req == 7'd18, "R7 pin restored", ratio_req, 18);

    // Rejected writes
    write_lim(20, 16);
    idle_cycles(64);
    check(ratio_req == 7'd18, "R5 inverted write ignored", ratio_req, 18);
    write_lim(8, 16);
    idle_cycles(64);
    check(ratio_req == 7'd18, "R5 out-of-range write ignored", ratio_req, 18);

    // Narrowed window and floor
    write_lim(13, 20);
    idle_cycles(64);
    check(ratio_req == 7'd20, "R6 ceiling clamp", ratio_req, 20);
    cache_act = 1'b0;
    idle_cycles(15 * 64);
    check(ratio_req == 7'd13, "R6 floor clamp", ratio_req, 13);
    write_lim(12, 24);
    idle_cycles(3 * 64);
    check(ratio_req == 7'd12, "R2 saturate at minimum", ratio_req, 12);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule